// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Detector

This block compares a reference clock with a divided-down loop clock and turns their phase difference into pump commands for a synthesizer loop. Both clocks arrive as levels that are synchronous to a faster oscillator clock, and every measurement is made in oscillator periods. The comparator keeps two event flags. The reference's rising edge sets one flag and the loop clock's rising edge sets the other. When both flags are up, one short balanced pulse is issued and both flags clear. Because of this pulse, a perfectly aligned loop still sees activity, so the loop has no dead zone.

A polarity input chooses which sense of the error drives the pump source and which drives the sink, and it swaps the two auxiliary comparator outputs in the same way. The lock detector measures the width of each error pulse. A wide pulse clears the lock flag. Three narrow comparisons in a row set it again. A monitor output shows either the lock flag or one of the two clocks. A power-save input holds the comparator idle and forces the lock flag high. A float input forces the pump command into high impedance.

Top module: `phase_cmp_ld`

## Requirements
- R1: With `fc`=1, when the reference edge has arrived and the loop edge has not (lead state), `do_cmd`=2'b10 (bit 1 sources high, bit 0 sinks low), `phi_r`=0 and `phi_p_pull`=1 (pulled low).
- R2: With `fc`=1, when the loop edge has arrived first (lag state), `do_cmd`=2'b01, `phi_r`=1 and `phi_p_pull`=0 (released).
- R3: In the idle state, and after reset, `do_cmd`=2'b00, `phi_r`=0, `phi_p_pull`=0 and `lock_det`=0.
- R4: With `fc`=0, the lead and lag states swap their outputs: lead gives `do_cmd`=2'b01, `phi_r`=1, `phi_p_pull`=0, and lag gives `do_cmd`=2'b10, `phi_r`=0, `phi_p_pull`=1.
- R5: When the second edge of a comparison arrives, or both edges arrive in the same cycle, `do_cmd`=2'b11 for exactly one cycle while `phi_r`=0 and `phi_p_pull`=0. The state then returns to idle, unless both clocks rise again in that same cycle.
- R6: Extra rising edges of the clock that is already ahead do not end or change an error pulse. Only the other clock's edge ends it.
- R7: While locked, the lock flag clears at the clock edge that ends the UNLOCK_CYC-th (8) oscillator cycle of a single error pulse.
- R8: While unlocked, a comparison whose error lasted at most LOCK_CYC (16) cycles counts as good. The flag sets at the edge that closes the LOCK_CONSEC-th (3) good comparison in a row.
- R9: A comparison whose error exceeded LOCK_CYC clears the count of good comparisons.
- R10: `mon`=`lock_det` when `lds`=0. When `lds`=1, `mon` follows `fr` if `fc`=1 and `fp` if `fc`=0.
- R11: While `pwr_save`=1, `lock_det`=1 and the comparator is held idle. After release, a comparison starts only from fresh rising edges.
- R12: `cp_float`=1 forces `do_cmd`=2'b00 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fr | input | 1 | Reference clock level, synchronous to clk |
| fp | input | 1 | Divided loop clock level, synchronous to clk |
| fc | input | 1 | Polarity select |
| lds | input | 1 | Monitor select: 0 lock flag, 1 clock |
| pwr_save | input | 1 | Power-save hold |
| cp_float | input | 1 | Forces the pump command to high impedance |
| do_cmd | output | 2 | Pump command {source, sink}, 00 = high impedance |
| phi_r | output | 1 | Auxiliary comparator level output |
| phi_p_pull | output | 1 | Auxiliary open-drain output, 1 = pulled low |
| lock_det | output | 1 | Lock flag |
| mon | output | 1 | Monitor output |

## Verification
The hardest behaviour to reach from the ports is the lock hysteresis. The band between 8 and 16 cycles makes the flag drop and rise again within a few periods, and one wide comparison in the middle of a run of narrow ones has to clear the count of good comparisons. The stimulus drives whole comparison periods with a chosen offset between the two clocks. It uses sustained coincidence, a sustained wide lag, and a repeating pattern of two aligned periods and one wide period. A behavioural model follows the flag every cycle. Separate steps send a second reference edge in the middle of a pulse and toggle power save while the clocks run.

// File: rtl/phase_cmp_pkg.sv
package phase_cmp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LAG  = 2'b01,
        PH_LEAD = 2'b10,
        PH_BOTH = 2'b11
    } ph_state_t;

    typedef struct packed {
        logic src;
        logic snk;
    } cp_cmd_t;

    typedef struct packed {
        logic r_lvl;
        logic p_pull;
    } aux_out_t;

    function automatic cp_cmd_t cp_decode(input ph_state_t s, input logic fc);
        cp_cmd_t c;
        case (s)
            PH_LEAD: c = fc ? '{src: 1'b1, snk: 1'b0} : '{src: 1'b0, snk: 1'b1};
            PH_LAG:  c = fc ? '{src: 1'b0, snk: 1'b1} : '{src: 1'b1, snk: 1'b0};
            PH_BOTH: c = '{src: 1'b1, snk: 1'b1};
            default: c = '{src: 1'b0, snk: 1'b0};
        endcase
        return c;
    endfunction

    function automatic aux_out_t aux_decode(input ph_state_t s, input logic fc);
        aux_out_t a;
        logic active_side;
        logic passive_side;
        active_side  = fc ? (s == PH_LEAD) : (s == PH_LAG);
        passive_side = fc ? (s == PH_LAG) : (s == PH_LEAD);
        a.r_lvl  = passive_side;
        a.p_pull = active_side;
        return a;
    endfunction

endpackage

// File: rtl/ph_edge_pfd.sv
module ph_edge_pfd
    import phase_cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] clk_lvl,
    input  logic       pwr_save,
    output ph_state_t  st
);
    localparam int NCH = 2;

    logic [NCH-1:0] prev_lvl;
    logic [NCH-1:0] rise;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) prev_lvl[gi] <= 1'b0;
                else     prev_lvl[gi] <= clk_lvl[gi];
            end
            assign rise[gi] = clk_lvl[gi] & ~prev_lvl[gi];
        end
    endgenerate

    ph_state_t st_nxt;

    always_comb begin
        if (st == PH_BOTH) st_nxt = ph_state_t'(rise);
        else               st_nxt = ph_state_t'(st | rise);
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_save) st <= PH_IDLE;
        else                 st <= st_nxt;
    end

    assert_lead_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (st == PH_LEAD) |=> (st != PH_LAG));

    assert_lag_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (st == PH_LAG) |=> (st != PH_LEAD));

    assert_both_single_R5: assert property (@(posedge clk) disable iff (rst)
        ((st == PH_BOTH) && (rise != 2'b11)) |=> (st != PH_BOTH));

    assert_save_idle_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_save |=> (st == PH_IDLE));

endmodule

// File: rtl/ph_lock_win.sv
module ph_lock_win
    import phase_cmp_pkg::*;
#(
    parameter int UNLOCK_CYC  = 8,
    parameter int LOCK_CYC    = 16,
    parameter int LOCK_CONSEC = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  ph_state_t st,
    input  logic      pwr_save,
    output logic      locked
);
    localparam int ERR_W  = $clog2(LOCK_CYC + 2);
    localparam int GOOD_W = $clog2(LOCK_CONSEC + 1);
    localparam logic [ERR_W-1:0]  ERR_MAX   = ERR_W'(LOCK_CYC + 1);
    localparam logic [ERR_W-1:0]  UNLK_LIM  = ERR_W'(UNLOCK_CYC);
    localparam logic [ERR_W-1:0]  LOCK_LIM  = ERR_W'(LOCK_CYC);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_CONSEC - 1);

    logic [ERR_W-1:0]  err_cnt;
    logic [ERR_W-1:0]  err_inc;
    logic [GOOD_W-1:0] good_cnt;

    assign err_inc = (err_cnt == ERR_MAX) ? err_cnt : err_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cnt  <= '0;
            good_cnt <= '0;
            locked   <= 1'b0;
        end else if (pwr_save) begin
            err_cnt  <= '0;
            good_cnt <= '0;
        end else begin
            case (st)
                PH_LEAD, PH_LAG: begin
                    err_cnt <= err_inc;
                    if (locked && (err_inc >= UNLK_LIM)) begin
                        locked   <= 1'b0;
                        good_cnt <= '0;
                    end
                end
                PH_BOTH: begin
                    err_cnt <= '0;
                    if (locked) begin
                        good_cnt <= '0;
                    end else if (err_cnt <= LOCK_LIM) begin
                        if (good_cnt == GOOD_LAST) begin
                            locked   <= 1'b1;
                            good_cnt <= '0;
                        end else begin
                            good_cnt <= good_cnt + 1'b1;
                        end
                    end else begin
                        good_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_rise_after_cmp_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(st) == PH_BOTH));

    assert_fall_in_error_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (($past(st) == PH_LEAD) || ($past(st) == PH_LAG)));

    assert_good_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        (good_cnt <= GOOD_LAST));

endmodule

// File: rtl/ph_out_map.sv
module ph_out_map
    import phase_cmp_pkg::*;
(
    input  ph_state_t  st,
    input  logic       fc,
    input  logic       cp_float,
    input  logic       lds,
    input  logic       pwr_save,
    input  logic       locked,
    input  logic       fr,
    input  logic       fp,
    output logic [1:0] do_cmd,
    output logic       phi_r,
    output logic       phi_p_pull,
    output logic       lock_det,
    output logic       mon
);
    cp_cmd_t  cmd;
    aux_out_t aux;

    always_comb begin
        cmd = cp_decode(st, fc);
        aux = aux_decode(st, fc);
        if (cp_float) cmd = '{src: 1'b0, snk: 1'b0};
    end

    assign do_cmd     = {cmd.src, cmd.snk};
    assign phi_r      = aux.r_lvl;
    assign phi_p_pull = aux.p_pull;
    assign lock_det   = locked | pwr_save;
    assign mon        = lds ? (fc ? fr : fp) : lock_det;

endmodule

// File: rtl/phase_cmp_ld.sv
module phase_cmp_ld
    import phase_cmp_pkg::*;
#(
    parameter int UNLOCK_CYC  = 8,
    parameter int LOCK_CYC    = 16,
    parameter int LOCK_CONSEC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fr,
    input  logic       fp,
    input  logic       fc,
    input  logic       lds,
    input  logic       pwr_save,
    input  logic       cp_float,
    output logic [1:0] do_cmd,
    output logic       phi_r,
    output logic       phi_p_pull,
    output logic       lock_det,
    output logic       mon
);
    ph_state_t st;
    logic      locked;

    ph_edge_pfd u_pfd (
        .clk      (clk),
        .rst      (rst),
        .clk_lvl  ({fr, fp}),
        .pwr_save (pwr_save),
        .st       (st)
    );

    ph_lock_win #(
        .UNLOCK_CYC  (UNLOCK_CYC),
        .LOCK_CYC    (LOCK_CYC),
        .LOCK_CONSEC (LOCK_CONSEC)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .pwr_save (pwr_save),
        .locked   (locked)
    );

    ph_out_map u_map (
        .st         (st),
        .fc         (fc),
        .cp_float   (cp_float),
        .lds        (lds),
        .pwr_save   (pwr_save),
        .locked     (locked),
        .fr         (fr),
        .fp         (fp),
        .do_cmd     (do_cmd),
        .phi_r      (phi_r),
        .phi_p_pull (phi_p_pull),
        .lock_det   (lock_det),
        .mon        (mon)
    );

    assert_float_idle_R12: assert property (@(posedge clk) disable iff (rst)
        cp_float |-> (do_cmd == 2'b00));

    assert_save_flag_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_save |-> lock_det);

endmodule

// File: tb/test_phase_cmp_ld.sv
module test_phase_cmp_ld;
    localparam int CLK_PERIOD = 10;
    localparam int UNLK = 8;
    localparam int LWIN = 16;
    localparam int NCONS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fr = 1'b0, fp = 1'b0, fc = 1'b1, lds = 1'b0, pwr_save = 1'b0, cp_float = 1'b0;
    logic [1:0] do_cmd;
    logic phi_r, phi_p_pull, lock_det, mon;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    phase_cmp_ld i_phase_cmp_ld (
        .clk(clk), .rst(rst), .fr(fr), .fp(fp), .fc(fc), .lds(lds),
        .pwr_save(pwr_save), .cp_float(cp_float), .do_cmd(do_cmd),
        .phi_r(phi_r), .phi_p_pull(phi_p_pull), .lock_det(lock_det), .mon(mon)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference: 0 idle, 1 lag, 2 lead, 3 both
    int m_st = 0, m_err = 0, m_good = 0;
    int m_lock = 0, m_frq = 0, m_fpq = 0;

    always @(posedge clk) begin
        int frr, fpr, nst;
        if (rst) begin
            m_st = 0; m_err = 0; m_good = 0; m_lock = 0; m_frq = 0; m_fpq = 0;
        end else begin
            frr = (fr && !m_frq) ? 1 : 0;
            fpr = (fp && !m_fpq) ? 1 : 0;
            m_frq = fr; m_fpq = fp;
            if (pwr_save) begin
                m_st = 0; m_err = 0; m_good = 0;
            end else begin
                if (m_st == 3) nst = frr * 2 + fpr;
                else           nst = m_st | (frr * 2 + fpr);
                if (m_st == 1 || m_st == 2) begin
                    m_err = (m_err >= LWIN + 1) ? m_err : m_err + 1;
                    if (m_lock == 1 && m_err >= UNLK) begin m_lock = 0; m_good = 0; end
                end else if (m_st == 3) begin
                    if (m_lock == 1) m_good = 0;
                    else if (m_err <= LWIN) begin
                        if (m_good + 1 >= NCONS) begin m_lock = 1; m_good = 0; end
                        else m_good = m_good + 1;
                    end else m_good = 0;
                    m_err = 0;
                end
                m_st = nst;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int e_do, e_r, e_p, active, passive, e_lk;
        string t_do, t_lk;
        if (!rst && !done) begin
            if (m_st == 2)      e_do = fc ? 2 : 1;
            else if (m_st == 1) e_do = fc ? 1 : 2;
            else if (m_st == 3) e_do = 3;
            else                e_do = 0;
            if (cp_float) e_do = 0;
            active  = fc ? (m_st == 2) : (m_st == 1);
            passive = fc ? (m_st == 1) : (m_st == 2);
            e_r = passive;
            e_p = active;
            e_lk = (m_lock == 1 || pwr_save) ? 1 : 0;
            if (cp_float)        t_do = "R12";
            else if (m_st == 3)  t_do = "R5";
            else if (m_st == 0)  t_do = "R3";
            else if (!fc)        t_do = "R4";
            else if (m_st == 2)  t_do = "R1";
            else                 t_do = "R2";
            if (pwr_save)        t_lk = "R11";
            else if (m_lock)     t_lk = "R7";
            else                 t_lk = "R8";
            chk(t_do, do_cmd, e_do);
            chk(t_do, phi_r, e_r);
            chk(t_do, phi_p_pull, e_p);
            chk(t_lk, lock_det, e_lk);
            chk("R10", mon, lds ? (fc ? fr : fp) : e_lk);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input logic f_r, input logic f_p);
        fr = f_r; fp = f_p;
        @(posedge clk); #1;
    endtask

    task automatic one_period(input int per, input int off);
        for (int c = 0; c < per; c++) begin
            int pc;
            pc = (c - off + per) % per;
            step(c < per / 2, pc < per / 2);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R3: reset state
        chk("R3", do_cmd, 0);
        chk("R3", lock_det, 0);
        rst = 1'b0;
        step(0, 0);
        step(0, 0);

        // R6 / R1 / R5: extra reference edge inside a lead pulse
        step(1, 0);
        chk("R1", do_cmd, 2);
        step(0, 0);
        step(1, 0);
        chk("R6", do_cmd, 2);
        chk("R6", phi_p_pull, 1);
        step(1, 1);
        chk("R5", do_cmd, 3);
        step(0, 0);
        chk("R3", do_cmd, 0);

        // R8: aligned clocks reach lock
        repeat (4) one_period(40, 0);
        chk("R8", lock_det, 1);

        // R7: sustained wide lag loses lock and stays unlocked
        repeat (4) one_period(40, 20);
        chk("R7", lock_det, 0);

        // R9: one wide comparison in every three restarts the count
        repeat (4) begin
            one_period(40, 0);
            one_period(40, 0);
            one_period(40, 18);
        end
        chk("R9", lock_det, 0);

        // hysteresis band and the loop clock leading
        repeat (6) one_period(40, 10);
        repeat (6) one_period(40, -5);

        // R4: reversed polarity
        fc = 1'b0;
        repeat (4) one_period(40, 6);
        repeat (4) one_period(40, -6);

        // R10: monitor selects a clock
        lds = 1'b1;
        repeat (2) one_period(30, 3);
        fc = 1'b1;
        repeat (2) one_period(30, -3);
        lds = 1'b0;

        // R12: float forces high impedance
        cp_float = 1'b1;
        repeat (3) one_period(40, 7);
        cp_float = 1'b0;

        // R11: power save with running clocks, then restart
        pwr_save = 1'b1;
        repeat (2) one_period(40, 12);
        chk("R11", lock_det, 1);
        chk("R11", do_cmd, 0);
        pwr_save = 1'b0;
        repeat (6) one_period(40, 0);
        chk("R11", lock_det, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule